// File: doc/BRIEF.md
# Multiplexed Dual-Mode Host Bus Front End

This block is the host-facing port of a small byte-wide register file. The host shares one 8-bit bus for address and data. An address strobe marks the address phase. A mode pin picks one of two cycle styles on the same pins. When the mode pin is high, one direction line says read or write, and a positive data strobe qualifies the cycle. When the mode pin is low, the direction line is an active-low write enable and the data strobe is an active-low output enable. The block holds a 128-byte register file that the low seven address bits select.

All host pins are asynchronous. Each one passes through a two-flop synchronizer on the system clock, and every edge is found from the synchronized samples. Host strobe pulses must last at least three system clocks. Address and write data must stay stable for several clocks after the strobe edge that captures them. The block drives read data on `busOut`, and `busOe` enables an external tri-state buffer.

Each access uses up the latched address. Before the next access, the host must send a new address strobe. An active power-fail input acts as if chip select were inactive, so nothing can be read or written.

Top module: `hostBusFront`

## Requirements
- R1: On a synchronized falling edge of `addrStrobe`, the block latches `busIn[6:0]` as the register address and marks it valid. Bit 7 is ignored, so address byte 0x80+n selects register n. This happens whatever the state of chip select.
- R2: A rising edge of `addrStrobe` invalidates the latched address. Later write or read strobes then have no effect until the next falling edge of `addrStrobe`.
- R3: A completed access also invalidates the address. A completed access is a write event, or the end of a read (the data strobe falling with `dirLine` high when `modeSel`=1, or the data strobe rising when `modeSel`=0). A second access without a new address strobe neither writes a register nor enables the bus.
- R4: A cycle made with `csN` high latches the address but writes nothing and leaves `busOe` low. It still uses up the address, so an access made afterwards with `csN` low and no new address strobe also does nothing.
- R5: While `powerFail` is 1, no register is written and `busOe` stays 0.
- R6: With `modeSel`=1, the falling edge of `dataStrobe` while `dirLine` is 0 writes `busIn` into the addressed register.
- R7: With `modeSel`=1, while `dataStrobe` is 1 and `dirLine` is 1 on a valid address with chip select active, `busOe` is 1 and `busOut` shows the addressed register.
- R8: With `modeSel`=0, the rising edge of `dirLine` (write enable) writes `busIn` into the addressed register.
- R9: With `modeSel`=0, while `dataStrobe` is 0 (output enable) on a valid address with chip select active, `busOe` is 1 and `busOut` shows the addressed register.
- R10: After reset `busOe` is 0. Outside a qualified read, `busOe` is 0 and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 1 | 1: direction line plus data strobe; 0: active-low OE/WE strobes |
| csN | input | 1 | Active-low chip select |
| addrStrobe | input | 1 | Address strobe; falling edge latches, rising edge clears |
| dirLine | input | 1 | Read/write level (mode 1) or active-low write enable (mode 0) |
| dataStrobe | input | 1 | Positive data strobe (mode 1) or active-low output enable (mode 0) |
| powerFail | input | 1 | 1 blocks every access |
| busIn | input | 8 | Multiplexed bus as seen by the block |
| busOut | output | 8 | Read data for the bus driver |
| busOe | output | 1 | Enable of the tri-state bus driver |

## Verification
The hardest case is a strobe that comes when the latched address is no longer valid. The address may have been cleared by a rising address strobe, used by an earlier access, or used by a cycle made with chip select high. In each of these cases the port signals look just like a legal cycle. The bench builds each case on purpose. It latches an address, completes or blocks one access, and then repeats the data strobe without a new address phase. It then reads the register back through a properly strobed cycle to show that it still holds the old value.

// File: rtl/hostBusPkg.sv
package hostBusPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;

  typedef struct packed {
    logic addrLoad;
    logic wrEn;
    logic busOe;
  } strobeT;
endpackage

// File: rtl/hostBusCtrl.sv
module hostBusCtrl
  import hostBusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   modeSel,
  input  logic   csN,
  input  logic   addrStrobe,
  input  logic   dirLine,
  input  logic   dataStrobe,
  input  logic   powerFail,
  output strobeT strb
);
  localparam int IDX_AS   = 0;
  localparam int IDX_DS   = 1;
  localparam int IDX_RW   = 2;
  localparam int IDX_CS   = 3;
  localparam int IDX_PF   = 4;
  localparam int IDX_MODE = 5;
  localparam int NPIN     = 6;
  localparam logic [NPIN-1:0] SYNC_RST = NPIN'(1 << IDX_CS) | NPIN'(1 << IDX_PF);

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] stage [SYNC_STAGES+1];
  logic [NPIN-1:0] cur, prev;
  logic addrValid;
  logic asFall, asRise, wrEvt, rdEnd, readCond, csAct;

  assign pins = {modeSel, powerFail, csN, dirLine, dataStrobe, addrStrobe};

  // Synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k <= SYNC_STAGES; k++) stage[k] <= SYNC_RST;
    end else begin
      stage[0] <= pins;
      for (int k = 1; k <= SYNC_STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign cur  = stage[SYNC_STAGES-1];
  assign prev = stage[SYNC_STAGES];

  assign asFall = prev[IDX_AS] & ~cur[IDX_AS];
  assign asRise = ~prev[IDX_AS] & cur[IDX_AS];
  assign csAct  = ~cur[IDX_CS] & ~cur[IDX_PF];

  always_comb begin
    if (cur[IDX_MODE]) begin
      wrEvt    = prev[IDX_DS] & ~cur[IDX_DS] & ~cur[IDX_RW];
      rdEnd    = prev[IDX_DS] & ~cur[IDX_DS] & cur[IDX_RW];
      readCond = cur[IDX_DS] & cur[IDX_RW];
    end else begin
      wrEvt    = ~prev[IDX_RW] & cur[IDX_RW];
      rdEnd    = ~prev[IDX_DS] & cur[IDX_DS];
      readCond = ~cur[IDX_DS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        addrValid <= 1'b0;
    else if (asFall)                  addrValid <= 1'b1;
    else if (asRise | wrEvt | rdEnd)  addrValid <= 1'b0;
  end

  assign strb.addrLoad = asFall;
  assign strb.wrEn     = wrEvt & csAct & addrValid;
  assign strb.busOe    = readCond & csAct & addrValid;

  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    asRise |=> !addrValid); // R2
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvt | rdEnd) && !asFall |=> !strb.wrEn && !addrValid); // R3
  AST_CS_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    cur[IDX_CS] |-> !strb.wrEn && !strb.busOe); // R4
  AST_PF_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    cur[IDX_PF] |-> !strb.wrEn && !strb.busOe); // R5
endmodule

// File: rtl/hostBusData.sv
module hostBusData
  import hostBusPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic [DW-1:0] busIn,
  output logic [DW-1:0] busOut,
  output logic          busOe
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] addrReg;
  logic [DW-1:0] regFile [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrReg <= '0;
    else if (strb.addrLoad) addrReg <= busIn[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) regFile[addrReg] <= busIn;
  end

  assign busOut = regFile[addrReg];
  assign busOe  = strb.busOe;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrLoad |=> addrReg == $past(busIn[AW-1:0])); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> regFile[$past(addrReg)] == $past(busIn)); // R6
endmodule

// File: rtl/hostBusFront.sv
module hostBusFront
  import hostBusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              csN,
  input  logic              addrStrobe,
  input  logic              dirLine,
  input  logic              dataStrobe,
  input  logic              powerFail,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);
  strobeT strb;

  hostBusCtrl #(.SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN),
    .addrStrobe(addrStrobe), .dirLine(dirLine), .dataStrobe(dataStrobe),
    .powerFail(powerFail), .strb(strb)
  );

  hostBusData #(.DW(DATA_W), .AW(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(busIn),
    .busOut(busOut), .busOe(busOe)
  );

  AST_OE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !busOe); // R10
endmodule

// File: tb/tb_hostBusFront.sv
module tb_hostBusFront;
  localparam int PERIOD = 10;
  localparam int SETTLE = 6;

  logic clk = 0, rstN = 0;
  logic modePin = 1, csPin = 0, asPin = 0, rwPin = 1, dsPin = 0, pfPin = 0;
  logic [7:0] busDrv = 0;
  logic [7:0] busOut;
  logic busOe;
  logic [7:0] refMem [128];
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  hostBusFront dut (
    .clk(clk), .rstN(rstN), .modeSel(modePin), .csN(csPin),
    .addrStrobe(asPin), .dirLine(rwPin), .dataStrobe(dsPin),
    .powerFail(pfPin), .busIn(busDrv), .busOut(busOut), .busOe(busOe)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic addrPhase(input logic [7:0] a);
    busDrv = a; asPin = 1; waitClk(SETTLE);
    asPin = 0; waitClk(SETTLE);
  endtask

  task automatic setMode(input logic m);
    modePin = m; rwPin = 1; dsPin = m ? 1'b0 : 1'b1; waitClk(SETTLE);
  endtask

  // data phase only (no address strobe)
  task automatic wrPulse(input logic [7:0] d);
    busDrv = d;
    if (modePin) begin
      rwPin = 0; dsPin = 1; waitClk(SETTLE); dsPin = 0; waitClk(SETTLE); rwPin = 1;
    end else begin
      rwPin = 0; waitClk(SETTLE); rwPin = 1; waitClk(SETTLE);
    end
    waitClk(2);
  endtask

  task automatic rdPulse(input string tag, input logic expOe, input logic [7:0] expD);
    rwPin = 1;
    dsPin = modePin ? 1'b1 : 1'b0; waitClk(SETTLE);
    if (expOe) check(tag, {busOe, busOut}, {1'b1, expD});
    else       check(tag, {busOe, 8'h00}, 9'h000);
    dsPin = modePin ? 1'b0 : 1'b1; waitClk(SETTLE);
    check({tag, " released"}, {8'h00, busOe}, 9'h000);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    addrPhase(a); wrPulse(d);
  endtask

  task automatic doRead(input string tag, input logic [7:0] a, input logic [7:0] expD);
    addrPhase(a); rdPulse(tag, 1'b1, expD);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    waitClk(3);
    check("R10 reset oe", {8'h00, busOe}, 9'h000);
    rstN = 1;
    waitClk(SETTLE);
    check("R10 idle oe", {8'h00, busOe}, 9'h000);

    // R6 sweep: mode 1 writes, R9 mode 0 reads; R1 via bit 7 set on writes
    setMode(1);
    for (int a = 0; a < 128; a++) begin
      refMem[a] = 8'((a * 37 + 11) ^ (a >> 2));
      doWrite(8'(a) | ((a % 2) ? 8'h80 : 8'h00), refMem[a]);
    end
    setMode(0);
    for (int a = 0; a < 128; a++) doRead("R6/R9/R1 sweep", 8'(a), refMem[a]);

    // R8 sweep: mode 0 writes, R7 mode 1 reads
    for (int a = 0; a < 128; a++) begin
      refMem[a] = 8'(~(a * 13) + 5);
      doWrite(8'(a), refMem[a]);
    end
    setMode(1);
    for (int a = 0; a < 128; a++) doRead("R8/R7 sweep", 8'(a) | 8'h80, refMem[a]);

    // R3 mode 1: second write and read without new strobe
    doWrite(8'd5, 8'hA5); refMem[5] = 8'hA5;
    wrPulse(8'h3C);
    rdPulse("R3 reuse read m1", 1'b0, 8'h00);
    doRead("R3 write ignored m1", 8'd5, refMem[5]);
    rdPulse("R3 second read m1", 1'b0, 8'h00);

    // R3 mode 0
    setMode(0);
    doWrite(8'd9, 8'h5A); refMem[9] = 8'h5A;
    wrPulse(8'hFF);
    doRead("R3 write ignored m0", 8'd9, refMem[9]);
    rdPulse("R3 second read m0", 1'b0, 8'h00);

    // R2: rising address strobe clears the address
    setMode(1);
    addrPhase(8'd20);
    asPin = 1; waitClk(SETTLE);
    wrPulse(8'h77);
    rdPulse("R2 read after rise", 1'b0, 8'h00);
    asPin = 0; waitClk(SETTLE);
    doRead("R2 write ignored", 8'd20, refMem[20]);

    // R4: chip select inactive consumes the address
    csPin = 1;
    doWrite(8'd30, 8'h99);
    addrPhase(8'd30);
    rdPulse("R4 read cs high", 1'b0, 8'h00);
    csPin = 0; waitClk(SETTLE);
    rdPulse("R4 read after cs cycle", 1'b0, 8'h00);
    doRead("R4 write ignored", 8'd30, refMem[30]);

    // R5: power fail blocks everything
    pfPin = 1; waitClk(SETTLE);
    doWrite(8'd40, 8'h12);
    addrPhase(8'd40);
    rdPulse("R5 read pf", 1'b0, 8'h00);
    setMode(0);
    doWrite(8'd41, 8'h34);
    addrPhase(8'd41);
    rdPulse("R5 read pf m0", 1'b0, 8'h00);
    pfPin = 0; waitClk(SETTLE);
    doRead("R5 write ignored", 8'd40, refMem[40]);
    doRead("R5 write ignored m0", 8'd41, refMem[41]);

    check("R10 final idle", {8'h00, busOe}, 9'h000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule